// File: doc/BRIEF.md
# Byte and Word Push Transmit Queue

This block is the staging queue that sits between a register write port and a serial shifter on the transmit side. Software writes either a single byte or a full 32-bit word. A word write enters the queue as four bytes at once. The shifter drains the queue one byte per cycle through a valid/ready handshake. The block publishes its free space, counted in bytes, in the upper half of a status word. It also raises empty, full and overrun events for the interrupt logic.

A write that needs more room than is free is discarded as a whole. The queue contents stay as they were, and the overrun event pulses for one cycle. The free space check uses the occupancy at the start of the cycle. A byte the shifter takes in the same cycle does not make room for that cycle's write.

The occupancy is tracked by a three-state machine:
- `ST_EMPTY` moves to `ST_PART` when an accepted write leaves the queue partly filled. It moves straight to `ST_FULL` when that write fills it.
- `ST_PART` moves to `ST_EMPTY` when the last byte leaves, and to `ST_FULL` when the occupancy reaches the depth.
- `ST_FULL` moves to `ST_PART` on any byte taken by the shifter.

In every other case the state holds.

Top module: `txq_fifo`

## Requirements
- R1: After reset the free field equals DEPTH (64), the empty event is high, and the full event, the overrun event and out_valid are low.
- R2: An accepted write with wr_sel=0 (byte port) adds exactly one byte to the queue, equal to wr_data[7:0]. Bits 31:8 are ignored.
- R3: An accepted write with wr_sel=1 (word port) adds four bytes. They leave in the order wr_data[7:0], [15:8], [23:16], [31:24].
- R4: out_valid is high whenever the queue holds a byte, and out_byte shows the oldest byte. While out_ready is low, that byte is held. Each cycle with out_valid and out_ready both high removes exactly one byte.
- R5: status_word[31:16] holds DEPTH minus the occupancy in bytes, and status_word[15:0] reads zero. Results show in the cycle after the clock edge that takes the write or the pop.
- R6: evt_empty is high exactly when the occupancy is zero. evt_full is high exactly when the occupancy equals DEPTH.
- R7: A write needing more bytes than are free is dropped whole, with no partial word stored. evt_overrun is high for the one cycle after that write, and is low otherwise.
- R8: The free space check uses the occupancy before any same-cycle pop. With a pop and an accepted write in the same cycle, the occupancy changes by the write size minus one.
- R9: Byte order is preserved across pointer wrap-around for any mix of byte writes, word writes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Port select: 0 byte port, 1 word port |
| wr_data | input | 32 | Written value |
| out_valid | output | 1 | A byte is offered to the shifter |
| out_ready | input | 1 | Shifter takes the offered byte |
| out_byte | output | 8 | Oldest queued byte |
| status_word | output | 32 | Free bytes in [31:16], zero in [15:0] |
| evt_empty | output | 1 | Queue empty event |
| evt_full | output | 1 | Queue full event |
| evt_overrun | output | 1 | One-cycle pulse after a rejected write |

## Verification
Every result of a write or a pop is due one cycle after the rising edge that samples it: the free field, the flags, out_valid, the head byte and the overrun pulse all follow the registered occupancy. The bench drives inputs on the falling edge and samples at the next falling edge, so each check lands in the cycle the result is due. A reference byte queue is updated from the pre-edge occupancy, which covers the rule that a same-cycle pop does not free room. Sweeps write a word at every fill level from 0 to 64 and then run a long mixed pattern across pointer wrap.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_t;

    localparam int WORD_BYTES = 4;
    localparam int FREE_W     = 16;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_accept,
    input  logic [2:0]    wr_nbytes,
    input  logic [AW-1:0] wr_ptr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_ptr,
    output logic [7:0]    rd_byte
);
    import txq_pkg::*;

    logic [7:0] mem [DEPTH];

    // lane i of the word lands i slots past the write pointer
    always_ff @(posedge clk) begin
        if (wr_accept) begin
            for (int i = 0; i < WORD_BYTES; i++) begin
                if (3'(i) < wr_nbytes) begin
                    mem[wr_ptr + AW'(i)] <= wr_data[8*i +: 8];
                end
            end
        end
    end

    assign rd_byte = mem[rd_ptr];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int FW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic          out_ready,
    output logic          wr_accept,
    output logic [2:0]    wr_nbytes,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [FW-1:0] free_bytes,
    output logic          out_valid,
    output logic          evt_empty,
    output logic          evt_full,
    output logic          evt_overrun
);
    import txq_pkg::*;

    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    occ_state_t    state, state_nxt;
    logic [CW-1:0] count, count_nxt, free_cur;
    logic          pop, ovr_q;

    assign wr_nbytes = wr_sel ? 3'(WORD_BYTES) : 3'd1;
    assign free_cur  = DEPTH_C - count;
    assign wr_accept = wr_en && (CW'(wr_nbytes) <= free_cur);
    assign pop       = out_valid && out_ready;
    assign count_nxt = count + (wr_accept ? CW'(wr_nbytes) : '0) - (pop ? CW'(1) : '0);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (wr_accept) state_nxt = (count_nxt == DEPTH_C) ? ST_FULL : ST_PART;
            ST_PART: begin
                if (count_nxt == '0)          state_nxt = ST_EMPTY;
                else if (count_nxt == DEPTH_C) state_nxt = ST_FULL;
            end
            ST_FULL:  if (pop) state_nxt = ST_PART;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            ovr_q  <= 1'b0;
        end else begin
            state  <= state_nxt;
            count  <= count_nxt;
            ovr_q  <= wr_en && !wr_accept;
            if (wr_accept) wr_ptr <= wr_ptr + AW'(wr_nbytes);
            if (pop)       rd_ptr <= rd_ptr + AW'(1);
        end
    end

    always_comb begin
        out_valid   = (state != ST_EMPTY);
        evt_empty   = (state == ST_EMPTY);
        evt_full    = (state == ST_FULL);
        evt_overrun = ovr_q;
        free_bytes  = FW'(free_cur);
    end
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_byte,
    output logic [31:0] status_word,
    output logic        evt_empty,
    output logic        evt_full,
    output logic        evt_overrun
);
    import txq_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic          wr_accept;
    logic [2:0]    wr_nbytes;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [FREE_W-1:0] free_bytes;

    txq_ctrl #(.DEPTH(DEPTH), .AW(AW), .FW(FREE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .out_ready(out_ready), .wr_accept(wr_accept), .wr_nbytes(wr_nbytes),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .free_bytes(free_bytes),
        .out_valid(out_valid), .evt_empty(evt_empty), .evt_full(evt_full),
        .evt_overrun(evt_overrun)
    );

    txq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .wr_accept(wr_accept), .wr_nbytes(wr_nbytes),
        .wr_ptr(wr_ptr), .wr_data(wr_data), .rd_ptr(rd_ptr), .rd_byte(out_byte)
    );

    assign status_word = {free_bytes, 16'h0000};
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_byte,
    input logic [31:0] status_word,
    input logic        evt_empty,
    input logic        evt_full,
    input logic        evt_overrun
);
    logic [15:0] free_f;
    logic        pop;
    assign free_f = status_word[31:16];
    assign pop    = out_valid && out_ready;

    assert_free_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        free_f <= 16'(DEPTH));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_empty, evt_full}));

    assert_empty_novalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty |-> (!out_valid && free_f == 16'(DEPTH)));

    assert_full_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |-> (free_f == 16'd0));

    assert_hold_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    assert_byte_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && free_f != 16'd0 && !pop) |=> (free_f == $past(free_f) - 16'd1));

    assert_word_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && free_f >= 16'd4 && !pop) |=> (free_f == $past(free_f) - 16'd4));

    assert_overrun_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && free_f < 16'd4 && !pop) |=> (evt_overrun && $stable(free_f)));

    assert_no_spurious_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> !evt_overrun);
endmodule

bind txq_fifo txq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .status_word(status_word), .evt_empty(evt_empty), .evt_full(evt_full),
    .evt_overrun(evt_overrun)
);

// File: tb/tb_txq_fifo.sv
module tb_txq_fifo;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, out_ready = 1'b0;
    logic [31:0] wr_data = '0;
    logic        out_valid, evt_empty, evt_full, evt_overrun;
    logic [7:0]  out_byte;
    logic [31:0] status_word;

    int total = 0, failed = 0;
    logic [7:0] q[$];

    always #2 clk = ~clk;

    txq_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .status_word(status_word), .evt_empty(evt_empty),
        .evt_full(evt_full), .evt_overrun(evt_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, sample at the next falling edge
    task automatic cyc(input logic en, input logic sel, input logic [31:0] d,
                       input logic rdy, input string dtag);
        int need, freeb;
        logic acc, pp;
        wr_en = en; wr_sel = sel; wr_data = d; out_ready = rdy;
        need  = sel ? 4 : 1;
        freeb = DEPTH - q.size();
        acc   = en && (need <= freeb);
        pp    = (q.size() > 0) && rdy;
        if (pp) void'(q.pop_front());
        if (acc) for (int i = 0; i < need; i++) q.push_back(d[8*i +: 8]);
        @(posedge clk);
        @(negedge clk);
        chk("R5 free", {16'h0, status_word[31:16]}, 32'(DEPTH - q.size()));
        chk("R5 low half", {16'h0, status_word[15:0]}, 32'h0);
        chk("R6 empty", {31'h0, evt_empty}, {31'h0, q.size() == 0});
        chk("R6 full", {31'h0, evt_full}, {31'h0, q.size() == DEPTH});
        chk("R4 valid", {31'h0, out_valid}, {31'h0, q.size() != 0});
        chk("R7 overrun", {31'h0, evt_overrun}, {31'h0, en && !acc});
        if (q.size() != 0) chk(dtag, {24'h0, out_byte}, {24'h0, q[0]});
    endtask

    task automatic drain(input string dtag);
        while (q.size() != 0) cyc(1'b0, 1'b0, 32'h0, 1'b1, dtag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 free", {16'h0, status_word[31:16]}, 32'(DEPTH));
        chk("R1 empty", {31'h0, evt_empty}, 32'h1);
        chk("R1 full", {31'h0, evt_full}, 32'h0);
        chk("R1 overrun", {31'h0, evt_overrun}, 32'h0);
        chk("R1 valid", {31'h0, out_valid}, 32'h0);

        // byte port keeps only bits 7:0
        cyc(1'b1, 1'b0, 32'hAABBCC11, 1'b0, "R2 byte data");
        // word port, low byte first
        cyc(1'b1, 1'b1, 32'h44332211, 1'b0, "R3 word order");
        cyc(1'b0, 1'b0, 32'h0, 1'b0, "R4 hold");
        cyc(1'b0, 1'b0, 32'h0, 1'b0, "R4 hold");
        drain("R3 word order");

        // fill to full with words from an offset pointer, then overrun
        for (int w = 0; w < DEPTH / 4; w++)
            cyc(1'b1, 1'b1, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, 1'b0, "R3 fill");
        cyc(1'b1, 1'b0, 32'h000000EE, 1'b0, "R7 byte dropped");
        cyc(1'b1, 1'b1, 32'hDEADBEEF, 1'b0, "R7 word dropped");
        cyc(1'b0, 1'b0, 32'h0, 1'b1, "R7 contents");
        // free is 1 before the pop: word must be rejected even with a pop
        cyc(1'b1, 1'b1, 32'h12345678, 1'b1, "R8 pre-pop check");
        drain("R9 wrap drain");

        // sweep a word write over every fill level
        for (int n = 0; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 32'(n + k), 1'b0, "R2 sweep");
            cyc(1'b1, 1'b1, {8'hD0, 8'hC0, 8'hB0, 8'(n)}, 1'b1, "R8 sweep");
            drain("R9 sweep drain");
        end

        // mixed traffic across many wraps
        lf = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] & lf[3], lf[1], {lf, lf ^ 16'h5A5A}, lf[2] | lf[5], "R9 mixed");
        end
        drain("R9 mixed drain");

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule